// File: doc/BRIEF.md
# Programmable field sequence selector

This block chooses which of six stored field-timing sets is in force for each video field. Software writes a 24-bit control word. The top three bits of the word give the length of a playlist, from 1 to 7 entries. The remaining 21 bits hold up to seven 3-bit entries, and each entry names a field index from 0 to 5. On every vertical sync pulse the block moves to the next entry. After the last entry in the programmed length it wraps back to the first, and it keeps cycling until software writes another word.

A written word does not act at once. It is held as pending and checked when the next sync pulse arrives. At that pulse the block either adopts the word and restarts from the first entry, or rejects it. A word is rejected if its length is zero or if any entry within the length holds code 6 or 7. On a rejection the error flag is raised and the sequence already running carries on undisturbed. The outputs give the selected field index, the current playlist position and the error flag. Downstream timing logic uses them to pick its vertical pattern set.

Top module: `field_seq_sel`

## Requirements
- R1: After reset, field_sel is 0, slot_pos is 0 and cfg_err is 0. The active playlist has length 1 with entry 0 set to field 0, so every vsync pulse before the first write leaves field_sel at 0 and slot_pos at 0.
- R2: In cfg_word, bits 23:21 give the playlist length. Entry n, counted from 0 to 6, occupies bits 3n+2:3n. Entry 0 is played first.
- R3: A write only makes the word pending. field_sel and slot_pos do not change because of it. At the next vsync pulse a legal pending word becomes active, slot_pos becomes 0 and field_sel shows entry 0 of the new word.
- R4: A vsync pulse with no word pending moves slot_pos up by one. field_sel always equals the code in the entry that slot_pos points to.
- R5: When slot_pos equals the length minus one, the next vsync pulse sets slot_pos to 0. The playlist repeats without limit. For example, 0x600088 plays fields 0,1,2; 0x400023 plays 3,4; and 0x80050D plays 5,1,4,2.
- R6: A pending word with length 0 is rejected at the vsync pulse. cfg_err becomes 1, and the running playlist advances as though nothing were pending.
- R7: A pending word with code 6 or 7 in any entry below its length is rejected in the same way as in R6.
- R8: Entries at positions equal to or above the length are neither checked nor played.
- R9: cfg_err keeps its value until a vsync pulse applies a pending word. It then becomes 0 if the word is accepted and 1 if it is rejected.
- R10: A write in the same cycle as a vsync pulse is not applied at that pulse. The pulse acts on the earlier state, and the written word is applied at the following pulse.
- R11: When several writes come before one vsync pulse, only the last of them is applied.
- R12: Without a vsync pulse, field_sel, slot_pos and cfg_err hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr | input | 1 | Single-cycle strobe that loads cfg_word as pending |
| cfg_word | input | 24 | Playlist length and entries |
| vsync | input | 1 | Single-cycle synchronous vertical sync pulse |
| field_sel | output | 3 | Field index now in force (0 to 5) |
| slot_pos | output | 3 | Playlist position now in force (0 to 6) |
| cfg_err | output | 1 | Last applied word was rejected |

## Verification
The hardest cases to reach from the ports are a rejection that arrives part-way through a running playlist, and a write that lands in the same cycle as a sync pulse. Both depend on the exact position the sequence has reached when the pending word is judged. The stimulus first pulses sync to walk a known playlist into its middle entry. It then loads an illegal word and checks that the position keeps advancing while the error flag rises. A separate task drives the write strobe and the sync pulse in one cycle. The position must follow the old playlist for that pulse and switch only at the next one.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int CNT_W     = 3;
  localparam int SLOT_W    = 3;
  localparam int NUM_SLOTS = 7;
  localparam int FIELD_MAX = 5;
  localparam int WORD_W    = CNT_W + NUM_SLOTS * SLOT_W;
  localparam logic [WORD_W-1:0] RESET_WORD = {CNT_W'(1), {(WORD_W-CNT_W){1'b0}}};
endpackage

// File: rtl/fss_word_check.sv
module fss_word_check #(
  parameter int CNT_W     = 3,
  parameter int SLOT_W    = 3,
  parameter int NUM_SLOTS = 7,
  parameter int FIELD_MAX = 5,
  localparam int WORD_W   = CNT_W + NUM_SLOTS * SLOT_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              legal
);
  logic [CNT_W-1:0]     len;
  logic [NUM_SLOTS-1:0] bad_slot;

  assign len = word[WORD_W-1 -: CNT_W];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [SLOT_W-1:0] code;
    logic              in_use;
    assign code        = word[i*SLOT_W +: SLOT_W];
    assign in_use      = (CNT_W'(i) < len);
    assign bad_slot[i] = in_use && (code > SLOT_W'(FIELD_MAX));
  end

  assign legal = (len != '0) && (bad_slot == '0);
endmodule

// File: rtl/fss_slot_mux.sv
module fss_slot_mux #(
  parameter int CNT_W     = 3,
  parameter int SLOT_W    = 3,
  parameter int NUM_SLOTS = 7,
  localparam int WORD_W   = CNT_W + NUM_SLOTS * SLOT_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  pos,
  output logic [SLOT_W-1:0] code
);
  logic [SLOT_W-1:0] entry [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_entry
    assign entry[i] = word[i*SLOT_W +: SLOT_W];
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (pos == CNT_W'(i)) code = entry[i];
    end
  end
endmodule

// File: rtl/fss_step.sv
module fss_step #(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] pos_nxt
);
  logic [CNT_W:0] pos_inc;

  assign pos_inc = {1'b0, pos} + {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    if (pos_inc >= {1'b0, len}) pos_nxt = '0;
    else                        pos_nxt = pos_inc[CNT_W-1:0];
  end
endmodule

// File: rtl/field_seq_sel.sv
module field_seq_sel
  import fss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              vsync,
  output logic [SLOT_W-1:0] field_sel,
  output logic [CNT_W-1:0]  slot_pos,
  output logic              cfg_err
);
  // reset synchronizer: asserts asynchronously, releases on clk
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // state
  logic [WORD_W-1:0] act_word, act_word_d;
  logic [WORD_W-1:0] pend_word;
  logic              pend_vld, pend_vld_d;
  logic [CNT_W-1:0]  pos_q, pos_d;
  logic              err_q, err_d;
  logic              act_en, pend_en, pend_vld_en, pos_en, err_en;

  logic              pend_ok;
  logic [CNT_W-1:0]  act_cnt;
  logic [CNT_W-1:0]  pos_step;
  logic              apply, accept, reject;

  assign act_cnt = act_word[WORD_W-1 -: CNT_W];

  fss_word_check #(
    .CNT_W(CNT_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .FIELD_MAX(FIELD_MAX)
  ) u_check (
    .word  (pend_word),
    .legal (pend_ok)
  );

  fss_step #(.CNT_W(CNT_W)) u_step (
    .pos     (pos_q),
    .len     (act_cnt),
    .pos_nxt (pos_step)
  );

  fss_slot_mux #(
    .CNT_W(CNT_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
  ) u_mux (
    .word (act_word),
    .pos  (pos_q),
    .code (field_sel)
  );

  // next-state
  always_comb begin
    apply       = vsync && pend_vld;
    accept      = apply && pend_ok;
    reject      = apply && !pend_ok;

    act_en      = accept;
    act_word_d  = pend_word;

    pos_en      = vsync;
    pos_d       = accept ? '0 : pos_step;

    err_en      = apply;
    err_d       = reject;

    pend_en     = cfg_wr;
    pend_vld_en = cfg_wr || vsync;
    pend_vld_d  = cfg_wr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      act_word  <= RESET_WORD;
      pend_word <= '0;
      pend_vld  <= 1'b0;
      pos_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      if (act_en)      act_word  <= act_word_d;
      if (pend_en)     pend_word <= cfg_word;
      if (pend_vld_en) pend_vld  <= pend_vld_d;
      if (pos_en)      pos_q     <= pos_d;
      if (err_en)      err_q     <= err_d;
    end
  end

  assign slot_pos = pos_q;
  assign cfg_err  = err_q;
endmodule

// File: rtl/fss_chk.sv
module fss_chk
  import fss_pkg::*;
(
  input logic              clk,
  input logic              rst_n_s,
  input logic              vsync,
  input logic              pend_vld,
  input logic              pend_ok,
  input logic [CNT_W-1:0]  act_cnt,
  input logic [CNT_W-1:0]  slot_pos,
  input logic [SLOT_W-1:0] field_sel,
  input logic              cfg_err
);
  AST_FIELD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n_s)
    field_sel <= SLOT_W'(FIELD_MAX)); // R7
  AST_POS_IN_LEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    slot_pos < act_cnt); // R5
  AST_HOLD_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n_s)
    !vsync |=> $stable(slot_pos) && $stable(field_sel) && $stable(cfg_err)); // R12
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n_s)
    vsync && pend_vld && pend_ok |=> slot_pos == '0 && !cfg_err); // R3
  AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n_s)
    vsync && pend_vld && !pend_ok |=> cfg_err); // R6
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n_s)
    vsync && !pend_vld && (slot_pos == act_cnt - CNT_W'(1)) |=> slot_pos == '0); // R5
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n_s)
    vsync && !pend_vld && (({1'b0, slot_pos} + 1'b1) < {1'b0, act_cnt})
    |=> slot_pos == $past(slot_pos) + CNT_W'(1)); // R4
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(vsync && pend_vld) |=> $stable(cfg_err)); // R9
endmodule

bind field_seq_sel fss_chk u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .vsync     (vsync),
  .pend_vld  (pend_vld),
  .pend_ok   (pend_ok),
  .act_cnt   (act_cnt),
  .slot_pos  (slot_pos),
  .field_sel (field_sel),
  .cfg_err   (cfg_err)
);

// File: tb/sim_field_seq_sel.sv
module sim_field_seq_sel;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [23:0] cfg_word;
  logic        vsync;
  logic [2:0]  field_sel;
  logic [2:0]  slot_pos;
  logic        cfg_err;

  int n_chk;
  int n_bad;
  bit done;

  field_seq_sel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .vsync(vsync), .field_sel(field_sel), .slot_pos(slot_pos), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // words and the field order expected over seven sync pulses, first in bits 2:0
  localparam int NV = 5;
  localparam logic [23:0] VW [NV] = '{24'h600088, 24'h400023, 24'h80050D, 24'hE2C688, 24'h20003B};
  localparam logic [20:0] VE [NV] = '{
    {3'd0, 3'd2, 3'd1, 3'd0, 3'd2, 3'd1, 3'd0},
    {3'd3, 3'd4, 3'd3, 3'd4, 3'd3, 3'd4, 3'd3},
    {3'd4, 3'd1, 3'd5, 3'd2, 3'd4, 3'd1, 3'd5},
    {3'd0, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
    {3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3}};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int f, input int s, input int e);
    chk({tag, " field_sel"}, int'(field_sel), f);
    chk({tag, " slot_pos"}, int'(slot_pos), s);
    chk({tag, " cfg_err"}, int'(cfg_err), e);
  endtask

  task automatic do_write(input logic [23:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_word = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  task automatic do_both(input logic [23:0] w);
    @(negedge clk); vsync = 1'b1; cfg_wr = 1'b1; cfg_word = w;
    @(negedge clk); vsync = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    cfg_wr = 1'b0; cfg_word = '0; vsync = 1'b0;
    do_reset();

    // R1 reset state and default playlist
    chk_all("R1 reset", 0, 0, 0);
    do_sync(); chk_all("R1 default sync", 0, 0, 0);
    do_sync(); chk_all("R1 default sync2", 0, 0, 0);

    // R3 pending write has no effect before sync
    do_write(24'h400023);
    repeat (3) @(negedge clk);
    chk_all("R3 pending hold", 0, 0, 0);

    // table walk: R2 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      int len;
      len = int'(VW[v][23:21]);
      do_write(VW[v]);
      for (int k = 0; k < 7; k++) begin
        do_sync();
        chk("R2 R4 R8 field_sel", int'(field_sel), int'(VE[v][k*3 +: 3]));
        chk("R5 slot_pos", int'(slot_pos), k % len);
        chk("R9 cfg_err", int'(cfg_err), 0);
      end
    end

    // R3 switch restarts at entry 0 (running 0x20003B)
    do_write(24'h600088);
    repeat (3) @(negedge clk);
    chk_all("R3 no sync yet", 3, 0, 0);
    do_sync(); chk_all("R3 switch", 0, 0, 0);
    do_sync(); chk_all("R4 step", 1, 1, 0);

    // R6 zero length rejected mid-playlist
    do_write(24'h000088);
    do_sync(); chk_all("R6 reject len0", 2, 2, 1);
    do_sync(); chk_all("R9 err held", 0, 0, 1);

    // R7 illegal code 6 in entry 2
    do_write(24'h600188);
    do_sync(); chk_all("R7 reject code6", 1, 1, 1);
    do_write(24'h400007);
    do_sync(); chk_all("R7 reject code7", 2, 2, 1);

    // R9 accept clears error
    do_write(24'h400023);
    do_sync(); chk_all("R9 clear", 3, 0, 0);

    // R10 write together with sync
    do_both(24'h600088);
    chk_all("R10 same cycle", 4, 1, 0);
    do_sync(); chk_all("R10 next sync", 0, 0, 0);

    // R11 last write wins
    do_write(24'h400023);
    do_write(24'h80050D);
    do_sync(); chk_all("R11 last write", 5, 0, 0);

    // R12 hold without sync
    repeat (6) @(negedge clk);
    chk_all("R12 idle hold", 5, 0, 0);
    do_sync(); chk_all("R12 then step", 1, 1, 0);

    // R1 reset in mid-run
    do_reset();
    chk_all("R1 re-reset", 0, 0, 0);
    do_sync(); chk_all("R1 re-reset sync", 0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule